// File: doc/BRIEF.md
# Table-Programmed Serial Flash Command Sequencer

This block runs serial NOR flash commands that are not fixed in logic. They are read at run time from a small lookup table. Each table entry is a program of four 32-bit words. Each word holds two 16-bit instructions, and each instruction is an opcode, a lane-width code and an 8-bit argument. A host starts an entry by giving its index, a flash address and a byte count. The engine then steps through the instructions and drives a single-lane SPI bus in mode 0 (clock idles low, data sampled on the rising edge). It sends command bytes, shifts out address bits, idles through dummy clocks, and moves data bytes through two simple byte streams.

The table is protected. A write reaches it only while the table is open. Opening it takes two steps: a key write of the agreed value, then a lock-control write carrying the open code. A lock-control write carrying the close code, again after the key, protects the table once more. Typical programs are:
- plain read: command, address, read;
- fast read: command, address, eight dummy clocks, read;
- page program: command, address, write;
- write-enable: a command on its own;
- status poll: command, then a one-byte read in the same word.

Top module: `lut_flash_seq`

## Requirements
- R1: Program n occupies table words 4n to 4n+3. Each word is executed lower half (bits 15:0) first, then upper half (bits 31:16). An instruction is opcode in bits 15:10, lane code in bits 9:8 and argument in bits 7:0. Opcode 1 is command, 2 is address, 3 is dummy, 4 is read and 5 is write.
- R2: After reset the table is closed. A table write while closed leaves the table unchanged. A lock-control write takes effect only if it is the first lock-control write after a key write of 0x5AF05AF0. Code 2'b10 opens the table and code 2'b01 closes it.
- R3: A command instruction sends its argument as 8 bits, MSB first, on `mosi`. Each bit takes two clocks with `sck` low and then high. `sck` pulses only while `cs_n` is low.
- R4: An address instruction sends the low A bits of the trigger address, MSB first, where A is the argument capped at 32. Argument 24 sends 24 bits and argument 32 sends 32 bits.
- R5: A dummy instruction gives as many `sck` pulses as its argument, with `mosi` low.
- R6: A read instruction moves N bytes, where N is the trigger byte count, or the argument when the count is zero. Each byte is assembled MSB first from `miso` sampled while `sck` is high. Each byte is presented on `rx_data` with a one-cycle `rx_valid` pulse.
- R7: A write instruction sends N bytes (N as in R6) taken from `tx_data`. `tx_pop` is high for one cycle each time a byte is taken.
- R8: A program ends at the first instruction with opcode 0, or with an opcode above 5, or with a nonzero lane code, or after its eighth instruction. `cs_n` stays low from the first instruction to that end.
- R9: A trigger whose first instruction ends the program (R8) gives a one-cycle `err` pulse. It gives no chip select, no clock and no busy.
- R10: `busy` rises the cycle after an accepted trigger. `done` pulses for one cycle in the cycle `cs_n` returns high, and `busy` falls in that same cycle. Triggers while busy are ignored.
- R11: In reset, `cs_n` is high, `sck` is low, and `busy`, `done`, `err`, `rx_valid` and `tx_pop` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbl_we | input | 1 | Table word write strobe |
| tbl_waddr | input | 5 | Table word index |
| tbl_wdata | input | 32 | Table word value |
| key_we | input | 1 | Key write strobe |
| key_wdata | input | 32 | Key value |
| lock_we | input | 1 | Lock-control write strobe |
| lock_wcode | input | 2 | Open (2'b10) or close (2'b01) code |
| trig | input | 1 | Start a program |
| trig_idx | input | 3 | Program index |
| trig_addr | input | 32 | Flash address |
| trig_len | input | 16 | Data byte count |
| busy | output | 1 | Program in progress |
| done | output | 1 | One-cycle end-of-program pulse |
| err | output | 1 | One-cycle empty-program pulse |
| sck | output | 1 | SPI clock |
| cs_n | output | 1 | SPI chip select, active low |
| mosi | output | 1 | SPI data out |
| miso | input | 1 | SPI data in |
| rx_valid | output | 1 | Read byte valid |
| rx_data | output | 8 | Read byte |
| tx_data | input | 8 | Next write byte |
| tx_pop | output | 1 | Write byte taken |

## Verification
The bench opens the table, writes one program of each kind, and compares every captured bus frame bit by bit against frames it builds from the trigger values.

It targets these corner cases:
- The 24-bit and 32-bit address widths. An engine that ignores the argument would send the wrong number of address bits.
- The dummy phase, which must keep `mosi` low.
- A zero trigger count, which must fall back to the read argument.
- A program that fills all eight instructions without a STOP. A wrong slot count would run past it or cut it short.
- A nonzero lane code. An engine that ignores it would go on into the read.

On the protection side, it writes while the table is closed, tries to open it without the key, and writes again after it has been closed. A broken lock would let those writes turn an empty program into a live one, and the trigger would then show bus activity instead of an error. A trigger issued while busy must not start a second frame.

// File: rtl/sfs_pkg.sv
package sfs_pkg;

    typedef enum logic [5:0] {
        OP_STOP  = 6'd0,
        OP_CMD   = 6'd1,
        OP_ADDR  = 6'd2,
        OP_DUMMY = 6'd3,
        OP_READ  = 6'd4,
        OP_WRITE = 6'd5
    } sfs_op_e;

    typedef struct packed {
        logic [5:0] op;
        logic [1:0] lanes;
        logic [7:0] arg;
    } sfs_ins_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOAD,
        ST_SHIFT,
        ST_FIN
    } sfs_state_e;

    typedef enum logic [1:0] {
        K_OUT,
        K_IN,
        K_WR
    } sfs_kind_e;

    localparam logic [1:0] CODE_CLOSE = 2'b01;
    localparam logic [1:0] CODE_OPEN  = 2'b10;

endpackage

// File: rtl/sfs_lock.sv
module sfs_lock #(
    parameter logic [31:0] KEY = 32'h5AF0_5AF0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        key_we,
    input  logic [31:0] key_wdata,
    input  logic        lock_we,
    input  logic [1:0]  lock_wcode,
    output logic        open
);
    import sfs_pkg::*;

    typedef struct packed {
        logic armed;
        logic open;
    } lk_t;

    lk_t q, d;

    always_comb begin
        d = q;
        if (lock_we) begin
            if (q.armed && lock_wcode == CODE_OPEN)  d.open = 1'b1;
            if (q.armed && lock_wcode == CODE_CLOSE) d.open = 1'b0;
            d.armed = 1'b0;
        end else if (key_we) begin
            d.armed = (key_wdata == KEY);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign open = q.open;
endmodule

// File: rtl/sfs_table.sv
module sfs_table #(
    parameter int AW    = 5,
    parameter int DEPTH = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          open,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [31:0]   wdata,
    input  logic [AW-1:0] raddr,
    output logic [31:0]   rdata
);
    logic [31:0] mem_q [DEPTH];
    logic [31:0] mem_d [DEPTH];

    always_comb begin
        mem_d = mem_q;
        if (we && open) mem_d[waddr] = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mem_q <= '{default: '0};
        else        mem_q <= mem_d;
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/sfs_walker.sv
module sfs_walker #(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16,
    parameter int SEQ_W  = 3,
    parameter int WPS    = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    trig,
    input  logic [SEQ_W-1:0]        trig_idx,
    input  logic [ADDR_W-1:0]       trig_addr,
    input  logic [LEN_W-1:0]        trig_len,
    output logic [SEQ_W+$clog2(WPS)-1:0] tbl_raddr,
    input  logic [31:0]             tbl_rdata,
    input  logic                    miso,
    input  logic [7:0]              tx_data,
    output logic                    busy,
    output logic                    done,
    output logic                    err,
    output logic                    sck,
    output logic                    cs_n,
    output logic                    mosi,
    output logic                    rx_valid,
    output logic [7:0]              rx_data,
    output logic                    tx_pop
);
    import sfs_pkg::*;

    localparam int SLOTS  = 2 * WPS;
    localparam int SLOT_W = $clog2(SLOTS) + 1;
    localparam int WSEL_W = $clog2(WPS);
    localparam int PADZ   = ADDR_W - 8;

    typedef struct packed {
        sfs_state_e        st;
        logic [SEQ_W-1:0]  seq;
        logic [SLOT_W-1:0] slot;
        logic [ADDR_W-1:0] sh;
        logic [7:0]        bits;
        logic [LEN_W-1:0]  bytes;
        sfs_kind_e         kind;
        logic [7:0]        rxsh;
        logic              phase;
        logic              sck;
        logic              cs_n;
        logic              busy;
        logic              done;
        logic              err;
        logic              rx_valid;
        logic [7:0]        rx_data;
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  len;
    } wk_t;

    wk_t      q, d;
    sfs_ins_t ins;
    logic     ins_end;
    logic     pop;
    logic [LEN_W-1:0] nbytes;
    logic [7:0]       abits;

    assign tbl_raddr = (q.st == ST_IDLE) ? {trig_idx, {WSEL_W{1'b0}}}
                                         : {q.seq, q.slot[SLOT_W-2:1]};
    assign ins     = (q.st != ST_IDLE && q.slot[0]) ? tbl_rdata[31:16] : tbl_rdata[15:0];
    assign ins_end = (ins.op == OP_STOP) || (ins.lanes != 2'b00) || (ins.op > OP_WRITE);
    assign nbytes  = (q.len != '0) ? q.len : LEN_W'(ins.arg);
    assign abits   = (ins.arg > 8'(ADDR_W)) ? 8'(ADDR_W) : ins.arg;

    always_comb begin
        d          = q;
        d.done     = 1'b0;
        d.err      = 1'b0;
        d.rx_valid = 1'b0;
        pop        = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (trig) begin
                    if (ins_end) begin
                        d.err = 1'b1;
                    end else begin
                        d.st   = ST_LOAD;
                        d.busy = 1'b1;
                        d.cs_n = 1'b0;
                        d.seq  = trig_idx;
                        d.slot = '0;
                        d.addr = trig_addr;
                        d.len  = trig_len;
                    end
                end
            end
            ST_LOAD: begin
                if (q.slot == SLOT_W'(SLOTS) || ins_end) begin
                    d.st = ST_FIN;
                end else begin
                    d.st    = ST_SHIFT;
                    d.phase = 1'b0;
                    d.bits  = 8'd8;
                    d.bytes = LEN_W'(1);
                    d.kind  = K_OUT;
                    d.sh    = '0;
                    case (ins.op)
                        OP_CMD: d.sh = {ins.arg, {PADZ{1'b0}}};
                        OP_ADDR: begin
                            d.bits = abits;
                            d.sh   = q.addr << (ADDR_W - int'(abits));
                        end
                        OP_DUMMY: d.bits = ins.arg;
                        OP_READ: begin
                            d.kind  = K_IN;
                            d.bytes = nbytes;
                        end
                        default: begin
                            d.kind  = K_WR;
                            d.bytes = nbytes;
                            d.sh    = {tx_data, {PADZ{1'b0}}};
                            pop     = (nbytes != '0);
                        end
                    endcase
                    if (d.bits == 8'd0 || d.bytes == '0) begin
                        d.st   = ST_LOAD;
                        d.slot = q.slot + SLOT_W'(1);
                    end
                end
            end
            ST_SHIFT: begin
                if (!q.phase) begin
                    d.phase = 1'b1;
                    d.sck   = 1'b1;
                end else begin
                    d.phase = 1'b0;
                    d.sck   = 1'b0;
                    d.rxsh  = {q.rxsh[6:0], miso};
                    d.sh    = q.sh << 1;
                    d.bits  = q.bits - 8'd1;
                    if (q.bits == 8'd1) begin
                        if (q.kind == K_IN) begin
                            d.rx_valid = 1'b1;
                            d.rx_data  = {q.rxsh[6:0], miso};
                        end
                        if (q.bytes == LEN_W'(1)) begin
                            d.st   = ST_LOAD;
                            d.slot = q.slot + SLOT_W'(1);
                        end else begin
                            d.bytes = q.bytes - LEN_W'(1);
                            d.bits  = 8'd8;
                            if (q.kind == K_WR) begin
                                d.sh = {tx_data, {PADZ{1'b0}}};
                                pop  = 1'b1;
                            end
                        end
                    end
                end
            end
            ST_FIN: begin
                d.st   = ST_IDLE;
                d.cs_n = 1'b1;
                d.busy = 1'b0;
                d.done = 1'b1;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.cs_n <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign busy     = q.busy;
    assign done     = q.done;
    assign err      = q.err;
    assign sck      = q.sck;
    assign cs_n     = q.cs_n;
    assign mosi     = !q.cs_n && q.sh[ADDR_W-1];
    assign rx_valid = q.rx_valid;
    assign rx_data  = q.rx_data;
    assign tx_pop   = pop;
endmodule

// File: rtl/lut_flash_seq.sv
module lut_flash_seq #(
    parameter int          NUM_SEQ = 8,
    parameter int          WPS     = 4,
    parameter int          ADDR_W  = 32,
    parameter int          LEN_W   = 16,
    parameter logic [31:0] KEY     = 32'h5AF0_5AF0,
    localparam int         SEQ_W   = $clog2(NUM_SEQ),
    localparam int         TBL_AW  = SEQ_W + $clog2(WPS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tbl_we,
    input  logic [TBL_AW-1:0] tbl_waddr,
    input  logic [31:0]       tbl_wdata,
    input  logic              key_we,
    input  logic [31:0]       key_wdata,
    input  logic              lock_we,
    input  logic [1:0]        lock_wcode,
    input  logic              trig,
    input  logic [SEQ_W-1:0]  trig_idx,
    input  logic [ADDR_W-1:0] trig_addr,
    input  logic [LEN_W-1:0]  trig_len,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic              sck,
    output logic              cs_n,
    output logic              mosi,
    input  logic              miso,
    output logic              rx_valid,
    output logic [7:0]        rx_data,
    input  logic [7:0]        tx_data,
    output logic              tx_pop
);
    localparam int DEPTH = NUM_SEQ * WPS;

    logic              open;
    logic [TBL_AW-1:0] raddr;
    logic [31:0]       rdata;

    sfs_lock #(.KEY(KEY)) i_lock (
        .clk(clk), .rst_n(rst_n),
        .key_we(key_we), .key_wdata(key_wdata),
        .lock_we(lock_we), .lock_wcode(lock_wcode),
        .open(open)
    );

    sfs_table #(.AW(TBL_AW), .DEPTH(DEPTH)) i_table (
        .clk(clk), .rst_n(rst_n), .open(open),
        .we(tbl_we), .waddr(tbl_waddr), .wdata(tbl_wdata),
        .raddr(raddr), .rdata(rdata)
    );

    sfs_walker #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .SEQ_W(SEQ_W), .WPS(WPS)) i_walker (
        .clk(clk), .rst_n(rst_n),
        .trig(trig), .trig_idx(trig_idx), .trig_addr(trig_addr), .trig_len(trig_len),
        .tbl_raddr(raddr), .tbl_rdata(rdata),
        .miso(miso), .tx_data(tx_data),
        .busy(busy), .done(done), .err(err),
        .sck(sck), .cs_n(cs_n), .mosi(mosi),
        .rx_valid(rx_valid), .rx_data(rx_data), .tx_pop(tx_pop)
    );
endmodule

// File: rtl/sfs_check.sv
module sfs_check (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic done,
    input logic err,
    input logic sck,
    input logic cs_n,
    input logic rx_valid,
    input logic tx_pop
);
    p_sck_in_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sck |-> !cs_n);

    p_frame_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |-> busy);

    p_done_at_cs_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cs_n && !$past(cs_n)));

    p_busy_fall_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    p_err_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (cs_n && !busy));

    p_rx_in_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> !cs_n);

    p_pop_in_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |-> !cs_n);
endmodule

bind lut_flash_seq sfs_check i_sfs_check (
    .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .err(err),
    .sck(sck), .cs_n(cs_n), .rx_valid(rx_valid), .tx_pop(tx_pop)
);

// File: tb/test_lut_flash_seq.sv
module test_lut_flash_seq;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] PAT    = 8'hA5;
    localparam logic [7:0] TXBASE = 8'h3C;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tbl_we = 1'b0;
    logic [4:0] tbl_waddr = '0;
    logic [31:0] tbl_wdata = '0;
    logic key_we = 1'b0;
    logic [31:0] key_wdata = '0;
    logic lock_we = 1'b0;
    logic [1:0] lock_wcode = '0;
    logic trig = 1'b0;
    logic [2:0] trig_idx = '0;
    logic [31:0] trig_addr = '0;
    logic [15:0] trig_len = '0;
    logic busy, done, err, sck, cs_n, mosi, rx_valid, tx_pop;
    logic [7:0] rx_data;
    logic miso_b = 1'b0;
    logic [7:0] tx_data;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lut_flash_seq i_lut_flash_seq (
        .clk(clk), .rst_n(rst_n),
        .tbl_we(tbl_we), .tbl_waddr(tbl_waddr), .tbl_wdata(tbl_wdata),
        .key_we(key_we), .key_wdata(key_wdata),
        .lock_we(lock_we), .lock_wcode(lock_wcode),
        .trig(trig), .trig_idx(trig_idx), .trig_addr(trig_addr), .trig_len(trig_len),
        .busy(busy), .done(done), .err(err),
        .sck(sck), .cs_n(cs_n), .mosi(mosi), .miso(miso_b),
        .rx_valid(rx_valid), .rx_data(rx_data), .tx_data(tx_data), .tx_pop(tx_pop)
    );

    // bus model: capture mosi, drive miso per frame-relative edge count
    logic [63:0] cap = '0;
    int fcnt = 0;
    int ntot = 0;
    always @(posedge sck or posedge cs_n) begin
        if (cs_n) begin
            fcnt = 0;
        end else begin
            logic [7:0] pb;
            fcnt = fcnt + 1;
            ntot = ntot + 1;
            cap  = {cap[62:0], mosi};
            pb   = PAT ^ 8'((fcnt - 1) / 8);
            miso_b = pb[7 - ((fcnt - 1) % 8)];
        end
    end

    int done_cnt = 0, err_cnt = 0, rx_tot = 0, tx_cnt = 0;
    logic pop_l = 1'b0;
    logic [7:0] rx_mem [64];
    assign tx_data = TXBASE + 8'(tx_cnt);
    always @(negedge clk) begin
        if (done) done_cnt = done_cnt + 1;
        if (err) err_cnt = err_cnt + 1;
        if (rx_valid) begin
            rx_mem[rx_tot % 64] = rx_data;
            rx_tot = rx_tot + 1;
        end
        if (pop_l) tx_cnt = tx_cnt + 1;
        pop_l = tx_pop;
    end

    typedef struct packed {
        logic [2:0]  idx;
        logic [31:0] addr;
        logic [15:0] len;
        logic [7:0]  edges;
        logic [7:0]  cmd;
        logic [5:0]  ab;
        logic [3:0]  nrd;
        logic [3:0]  nwr;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{3'd0, 32'h00123456, 16'd3, 8'd56, 8'h03, 6'd24, 4'd3, 4'd0},
        '{3'd1, 32'h89ABCDEF, 16'd2, 8'd64, 8'h0C, 6'd32, 4'd2, 4'd0},
        '{3'd2, 32'h0000FF01, 16'd2, 8'd48, 8'h02, 6'd24, 4'd0, 4'd2},
        '{3'd3, 32'h00000000, 16'd0, 8'd16, 8'h05, 6'd0,  4'd1, 4'd0},
        '{3'd3, 32'h00000000, 16'd2, 8'd24, 8'h05, 6'd0,  4'd2, 4'd0},
        '{3'd4, 32'hFFFFFFFF, 16'd0, 8'd8,  8'h06, 6'd0,  4'd0, 4'd0},
        '{3'd7, 32'h00000000, 16'd5, 8'd8,  8'h9F, 6'd0,  4'd0, 4'd0},
        '{3'd0, 32'hFEDCBA98, 16'd1, 8'd40, 8'h03, 6'd24, 4'd1, 4'd0}
    };

    function automatic logic [15:0] ins(input logic [5:0] op, input logic [7:0] a);
        return {op, 2'b00, a};
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr_tbl(input int a, input logic [31:0] v);
        @(negedge clk); tbl_we = 1'b1; tbl_waddr = 5'(a); tbl_wdata = v;
        @(negedge clk); tbl_we = 1'b0;
    endtask

    task automatic lock_op(input logic [31:0] key, input logic use_key, input logic [1:0] code);
        if (use_key) begin
            @(negedge clk); key_we = 1'b1; key_wdata = key;
            @(negedge clk); key_we = 1'b0;
        end
        @(negedge clk); lock_we = 1'b1; lock_wcode = code;
        @(negedge clk); lock_we = 1'b0;
    endtask

    task automatic fire(input logic [2:0] idx, input logic [31:0] a, input logic [15:0] l);
        @(negedge clk); trig = 1'b1; trig_idx = idx; trig_addr = a; trig_len = l;
        @(negedge clk); trig = 1'b0;
    endtask

    task automatic settle(input int d0);
        int g = 0;
        while (done_cnt == d0 && g < 3000) begin
            @(negedge clk); g++;
        end
        repeat (4) @(negedge clk);
    endtask

    initial begin
        int n0, d0, e0, r0, t0;
        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11 cs_n in reset", 64'(cs_n), 64'd1);
        chk("R11 sck in reset", 64'(sck), 64'd0);
        chk("R11 busy in reset", 64'(busy), 64'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R11 done after reset", 64'(done), 64'd0);

        // R2: write while closed, then open attempt without key
        wr_tbl(0, {16'h0, ins(6'd1, 8'h9F)});
        n0 = ntot; e0 = err_cnt;
        fire(3'd0, 32'h0, 16'd0);
        repeat (4) @(negedge clk);
        chk("R2 closed write ignored (err)", 64'(err_cnt - e0), 64'd1);
        chk("R9 empty program no clocks", 64'(ntot - n0), 64'd0);
        chk("R9 empty program not busy", 64'(busy), 64'd0);
        lock_op(32'h0, 1'b0, 2'b10);
        wr_tbl(0, {16'h0, ins(6'd1, 8'h9F)});
        e0 = err_cnt; n0 = ntot;
        fire(3'd0, 32'h0, 16'd0);
        repeat (4) @(negedge clk);
        chk("R2 open without key ignored", 64'(err_cnt - e0), 64'd1);
        chk("R2 open without key no clocks", 64'(ntot - n0), 64'd0);

        // open properly and program
        lock_op(32'h5AF0_5AF0, 1'b1, 2'b10);
        wr_tbl(0,  {ins(6'd2, 8'd24), ins(6'd1, 8'h03)});
        wr_tbl(1,  {16'h0, ins(6'd4, 8'd0)});
        wr_tbl(4,  {ins(6'd2, 8'd32), ins(6'd1, 8'h0C)});
        wr_tbl(5,  {ins(6'd4, 8'd0), ins(6'd3, 8'd8)});
        wr_tbl(8,  {ins(6'd2, 8'd24), ins(6'd1, 8'h02)});
        wr_tbl(9,  {16'h0, ins(6'd5, 8'd0)});
        wr_tbl(12, {ins(6'd4, 8'd1), ins(6'd1, 8'h05)});
        wr_tbl(16, {16'h0, ins(6'd1, 8'h06)});
        for (int w = 0; w < 4; w++)
            wr_tbl(24 + w, {ins(6'd1, 8'hA1 + 8'(2*w)), ins(6'd1, 8'hA0 + 8'(2*w))});
        wr_tbl(28, {6'd4, 2'b01, 8'd0, ins(6'd1, 8'h9F)});
        lock_op(32'h5AF0_5AF0, 1'b1, 2'b01);
        wr_tbl(20, {16'h0, ins(6'd1, 8'h77)});

        // vector walk: R1 R3 R4 R5 R6 R7 R8 R10
        for (int v = 0; v < 8; v++) begin
            int edges, dmy, off;
            vec_t t;
            logic [63:0] m;
            t = VECS[v];
            edges = int'(t.edges);
            n0 = ntot; d0 = done_cnt; r0 = rx_tot; t0 = tx_cnt;
            fire(t.idx, t.addr, t.len);
            chk($sformatf("R10 busy after trigger v%0d", v), 64'(busy), 64'd1);
            settle(d0);
            chk($sformatf("R8 edge count v%0d", v), 64'(ntot - n0), 64'(edges));
            chk($sformatf("R10 one done v%0d", v), 64'(done_cnt - d0), 64'd1);
            chk($sformatf("R10 idle after done v%0d", v), 64'({busy, cs_n}), 64'b01);
            chk($sformatf("R3 command byte v%0d", v), (cap >> (edges - 8)) & 64'hFF, 64'(t.cmd));
            if (t.ab != 0) begin
                m = (64'd1 << t.ab) - 64'd1;
                chk($sformatf("R4 address bits v%0d", v),
                    (cap >> (edges - 8 - int'(t.ab))) & m, 64'(t.addr) & m);
            end
            dmy = edges - 8 - int'(t.ab) - 8 * (int'(t.nrd) + int'(t.nwr));
            if (dmy > 0) begin
                m = (64'd1 << dmy) - 64'd1;
                chk($sformatf("R5 dummy low v%0d", v),
                    (cap >> (8 * (int'(t.nrd) + int'(t.nwr)))) & m, 64'd0);
            end
            chk($sformatf("R6 read count v%0d", v), 64'(rx_tot - r0), 64'(t.nrd));
            off = edges / 8 - int'(t.nrd);
            for (int j = 0; j < int'(t.nrd); j++)
                chk($sformatf("R6 read byte %0d v%0d", j, v),
                    64'(rx_mem[(r0 + j) % 64]), 64'(PAT ^ 8'(off + j)));
            chk($sformatf("R7 pop count v%0d", v), 64'(tx_cnt - t0), 64'(t.nwr));
            for (int j = 0; j < int'(t.nwr); j++)
                chk($sformatf("R7 write byte %0d v%0d", j, v),
                    (cap >> (8 * (int'(t.nwr) - 1 - j))) & 64'hFF, 64'(TXBASE + 8'(t0 + j)));
        end

        // R1 R8: eight command slots, no STOP, in lower-then-upper order
        n0 = ntot; d0 = done_cnt;
        fire(3'd6, 32'h0, 16'd0);
        settle(d0);
        chk("R8 full program edges", 64'(ntot - n0), 64'd64);
        chk("R1 slot order", cap, 64'hA0A1A2A3A4A5A6A7);

        // R2: write after relock ignored; R9 empty program error
        n0 = ntot; e0 = err_cnt;
        fire(3'd5, 32'h0, 16'd0);
        repeat (4) @(negedge clk);
        chk("R2 relocked write ignored", 64'(err_cnt - e0), 64'd1);
        chk("R9 no clocks on empty", 64'(ntot - n0), 64'd0);

        // R10: trigger while busy is ignored
        n0 = ntot; d0 = done_cnt;
        fire(3'd4, 32'h0, 16'd0);
        fire(3'd0, 32'h123, 16'd4);
        settle(d0);
        repeat (40) @(negedge clk);
        chk("R10 busy trigger ignored edges", 64'(ntot - n0), 64'd8);
        chk("R10 busy trigger ignored done", 64'(done_cnt - d0), 64'd1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks = checks + 1;
        errors = errors + 1;
        $display("FAIL watchdog expired actual 1 expected 0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule